// File: doc/BRIEF.md
# Loadable Synchronous Binary Up Counter

This block is a binary up counter that changes state only on the rising edge of a single clock. On any edge it can take one of four actions: advance by one, take a parallel word from its data input, return to zero, or keep its value. Two count-enable inputs must both be high before the counter advances. The clear input acts only while counting is stopped. A ripple-carry output marks the all-ones state so that several stages can be chained into a wider counter. The first stage's carry then drives the T enable of the next.

A range wrapper sits on the load path. When range mode is on, the wrapper watches for a terminal value. When the count reaches it, the wrapper requests a load of a start value. The count therefore cycles over the closed interval from the start value to the terminal value. The terminal value is shown for a full cycle before the start value returns. Both values are parameters, and the terminal value must be no smaller than the start value. A synchronous active-high reset puts the count at zero.

Top module: `loadable_up_counter`

## Requirements
- R1: On the first cycle after the synchronous reset `rst` is released, `count` is 0.
- R2: When `en_p` and `en_t` are both 1, and neither a clear nor a load applies, `count` rises by one on the next rising edge.
- R3: When `en_p` or `en_t` is 0, `load_n` is 1 and no clear or terminal reload applies, `count` keeps its value across the edge.
- R4: With `load_n` at 0, `load_data` is taken into `count` on the next rising edge. Before that edge, `count` still shows its previous value.
- R5: With `clear_n` at 0 and `en_p` or `en_t` at 0, `count` becomes 0 on the next rising edge.
- R6: A low `clear_n` has no effect while `en_p` and `en_t` are both 1, and the count then advances normally.
- R7: Priority on one edge is clear (when disabled), then load, then counting. An external load takes precedence over the terminal reload, so its data wins.
- R8: `rco` is 1 exactly when `en_t` is 1 and `count` is all ones (15 at the default width), and it holds for that whole cycle.
- R9: Up-counting wraps from all ones to 0; after loading 12, the sequence is 12, 13, 14, 15, 0, 1, 2.
- R10: With `range_en` at 1, a count equal to the terminal value (13 by default) is held for one cycle and then replaced by the start value (3 by default), giving 3..13 repeating.
- R11: With `range_en` at 0, the terminal value gives no reload, and 13 is followed by 14.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| en_p | input | 1 | Count enable, parallel side |
| en_t | input | 1 | Count enable, carry side; also gates `rco` |
| load_n | input | 1 | Active-low synchronous parallel load |
| clear_n | input | 1 | Active-low synchronous clear, honoured only while disabled |
| load_data | input | WIDTH | Parallel load word |
| range_en | input | 1 | Enables the start/terminal reload wrapper |
| count | output | WIDTH | Current count |
| rco | output | 1 | Ripple carry for cascading |

## Verification
Two controls can collide on the same edge in two ways. One is a clear against a load or a count; the other is the terminal reload against an external load. The bench provokes both on purpose. It drives `clear_n` and `load_n` low together, once with counting stopped and once with it running. It also drives an external load on the cycle the count sits at the terminal value with range mode on. A reference model built from the priority order predicts each following count, and the scoreboard compares it on the next falling edge.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_COUNT = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } cnt_op_e;

    typedef struct packed {
        logic en_p;
        logic en_t;
        logic load_n;
        logic clear_n;
    } cnt_ctl_t;

    function automatic logic both_enabled(cnt_ctl_t c);
        return c.en_p & c.en_t;
    endfunction

    // clear (only while stopped) > load > count > hold
    function automatic cnt_op_e pick_op(cnt_ctl_t c);
        cnt_op_e op;
        if (!c.clear_n && !both_enabled(c))
            op = OP_CLEAR;
        else if (!c.load_n)
            op = OP_LOAD;
        else if (both_enabled(c))
            op = OP_COUNT;
        else
            op = OP_HOLD;
        return op;
    endfunction

endpackage

// File: rtl/cnt_op_decode.sv
module cnt_op_decode
    import cnt_pkg::*;
(
    input  cnt_ctl_t ctl,
    output cnt_op_e  op
);
    always_comb begin
        op = pick_op(ctl);
    end
endmodule

// File: rtl/cnt_range_wrap.sv
module cnt_range_wrap #(
    parameter int WIDTH       = 4,
    parameter int RANGE_START = 3,
    parameter int RANGE_TERM  = 13
) (
    input  logic             range_en,
    input  logic [WIDTH-1:0] cur,
    input  logic             ext_load_n,
    input  logic [WIDTH-1:0] ext_data,
    output logic             eff_load_n,
    output logic [WIDTH-1:0] eff_data
);
    localparam logic [WIDTH-1:0] START_V = RANGE_START[WIDTH-1:0];
    localparam logic [WIDTH-1:0] TERM_V  = RANGE_TERM[WIDTH-1:0];

    logic term_hit;

    always_comb begin
        term_hit   = range_en && (cur == TERM_V);
        eff_load_n = ext_load_n & ~term_hit;
        // an external load keeps its own data
        eff_data   = !ext_load_n ? ext_data : START_V;
    end
endmodule

// File: rtl/cnt_stage.sv
module cnt_stage
    import cnt_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  cnt_op_e          op,
    input  logic [WIDTH-1:0] data,
    input  logic             en_t,
    output logic [WIDTH-1:0] q,
    output logic             rco
);
    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            unique case (op)
                OP_CLEAR: q <= '0;
                OP_LOAD:  q <= data;
                OP_COUNT: q <= q + 1'b1;
                default:  q <= q;
            endcase
        end
    end

    always_comb begin
        rco = en_t && (q == ALL_ONES);
    end
endmodule

// File: rtl/loadable_up_counter.sv
module loadable_up_counter
    import cnt_pkg::*;
#(
    parameter int WIDTH       = 4,
    parameter int RANGE_START = 3,
    parameter int RANGE_TERM  = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_p,
    input  logic             en_t,
    input  logic             load_n,
    input  logic             clear_n,
    input  logic [WIDTH-1:0] load_data,
    input  logic             range_en,
    output logic [WIDTH-1:0] count,
    output logic             rco
);
    cnt_ctl_t         ctl;
    cnt_op_e          op;
    logic             eff_load_n;
    logic [WIDTH-1:0] eff_data;
    logic [WIDTH-1:0] q;

    cnt_range_wrap #(
        .WIDTH      (WIDTH),
        .RANGE_START(RANGE_START),
        .RANGE_TERM (RANGE_TERM)
    ) u_wrap (
        .range_en  (range_en),
        .cur       (q),
        .ext_load_n(load_n),
        .ext_data  (load_data),
        .eff_load_n(eff_load_n),
        .eff_data  (eff_data)
    );

    always_comb begin
        ctl.en_p    = en_p;
        ctl.en_t    = en_t;
        ctl.load_n  = eff_load_n;
        ctl.clear_n = clear_n;
    end

    cnt_op_decode u_dec (
        .ctl(ctl),
        .op (op)
    );

    cnt_stage #(.WIDTH(WIDTH)) u_stage (
        .clk (clk),
        .rst (rst),
        .op  (op),
        .data(eff_data),
        .en_t(en_t),
        .q   (q),
        .rco (rco)
    );

    assign count = q;
endmodule

// File: rtl/loadable_up_counter_chk.sv
module loadable_up_counter_chk #(
    parameter int WIDTH       = 4,
    parameter int RANGE_START = 3,
    parameter int RANGE_TERM  = 13
) (
    input logic             clk,
    input logic             rst,
    input logic             en_p,
    input logic             en_t,
    input logic             load_n,
    input logic             clear_n,
    input logic [WIDTH-1:0] load_data,
    input logic             range_en,
    input logic [WIDTH-1:0] count,
    input logic             rco
);
    localparam logic [WIDTH-1:0] START_V = RANGE_START[WIDTH-1:0];
    localparam logic [WIDTH-1:0] TERM_V  = RANGE_TERM[WIDTH-1:0];

    logic run, hit, clr_ok;
    assign run    = en_p && en_t;
    assign hit    = range_en && (count == TERM_V);
    assign clr_ok = !clear_n && !run;

    p_reset_zero_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> count == '0);

    p_count_up_r2: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && run && load_n && !hit) |-> count == $past(count) + 1'b1);

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && !run && load_n && clear_n && !hit) |-> $stable(count));

    p_load_r4: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && !load_n && !clr_ok) |-> count == $past(load_data));

    p_clear_r5: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && clr_ok) |-> count == '0);

    p_rco_r8: assert property (@(posedge clk) disable iff (rst)
        rco |-> (en_t && (&count)));

    p_range_reload_r10: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && hit && load_n && !clr_ok) |-> count == START_V);
endmodule

bind loadable_up_counter loadable_up_counter_chk #(
    .WIDTH      (WIDTH),
    .RANGE_START(RANGE_START),
    .RANGE_TERM (RANGE_TERM)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .en_p     (en_p),
    .en_t     (en_t),
    .load_n   (load_n),
    .clear_n  (clear_n),
    .load_data(load_data),
    .range_en (range_en),
    .count    (count),
    .rco      (rco)
);

// File: tb/loadable_up_counter_tb.sv
module loadable_up_counter_tb;
    localparam int W = 4;

    typedef struct {
        logic [W-1:0] val;
        string        req;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en_p = 1'b0, en_t = 1'b0, load_n = 1'b1, clear_n = 1'b1, range_en = 1'b0;
    logic [W-1:0] load_data = '0;
    logic [W-1:0] count;
    logic         rco;

    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;
    exp_t sb[$];
    logic [W-1:0] model = '0;

    always #10 clk = ~clk;

    loadable_up_counter u_dut (
        .clk(clk), .rst(rst), .en_p(en_p), .en_t(en_t), .load_n(load_n),
        .clear_n(clear_n), .load_data(load_data), .range_en(range_en),
        .count(count), .rco(rco)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one clock: drive, check pre-edge outputs, predict, push
    task automatic step(input logic p, input logic t, input logic ld, input logic cl,
                        input logic rg, input logic [W-1:0] d, input string req);
        logic [W-1:0] nxt;
        en_p = p; en_t = t; load_n = ld; clear_n = cl; range_en = rg; load_data = d;
        #2;
        chk(rco == (t && model == 4'd15), "R8", int'(rco), int'(t && model == 4'd15));
        if (!ld) chk(count == model, "R4", int'(count), int'(model));
        if (!cl && !(p && t))      nxt = '0;
        else if (!ld)              nxt = d;
        else if (rg && model == 4'd13) nxt = 4'd3;
        else if (p && t)           nxt = model + 1'b1;
        else                       nxt = model;
        @(posedge clk);
        model = nxt;
        sb.push_back('{nxt, req});
        #3;
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            while (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                chk(count == e.val, e.req, int'(count), int'(e.val));
            end
        end
    end

    // watchdog
    initial begin
        #1000000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(posedge clk); @(posedge clk); #3;
        rst = 1'b0;
        model = '0;
        @(posedge clk);
        sb.push_back('{4'd0, "R1"});
        #3;
        chk(rco == 1'b0, "R1", int'(rco), 0);

        // free count through wrap (R2, R9, R8 at 15)
        for (int i = 0; i < 17; i++) step(1, 1, 1, 1, 0, 4'd0, (i == 15) ? "R9" : "R2");
        // hold with either enable low (R3)
        for (int i = 0; i < 3; i++) step(0, 1, 1, 1, 0, 4'd0, "R3");
        for (int i = 0; i < 3; i++) step(1, 0, 1, 1, 0, 4'd0, "R3");
        // load 15, rco gated by en_t (R8)
        step(0, 0, 0, 1, 0, 4'd15, "R4");
        step(1, 0, 1, 1, 0, 4'd0, "R8");
        step(0, 1, 1, 1, 0, 4'd0, "R8");
        // load 12 then 12,13,14,15,0,1,2 (R9)
        step(0, 0, 0, 1, 0, 4'd12, "R4");
        for (int i = 0; i < 6; i++) step(1, 1, 1, 1, 0, 4'd0, "R9");
        // clear while stopped (R5), ignored while running (R6)
        step(0, 1, 1, 0, 0, 4'd0, "R5");
        step(0, 0, 0, 1, 0, 4'd9, "R4");
        step(1, 1, 1, 0, 0, 4'd0, "R6");
        step(1, 1, 1, 0, 0, 4'd0, "R6");
        // collisions (R7)
        step(1, 0, 0, 0, 0, 4'd7, "R7");
        step(1, 1, 0, 0, 0, 4'd7, "R7");
        step(1, 1, 0, 1, 0, 4'd4, "R7");
        // truncated range 3..13 (R10)
        step(0, 0, 0, 1, 0, 4'd11, "R4");
        for (int i = 0; i < 25; i++) step(1, 1, 1, 1, 1, 4'd0, "R10");
        // reach 13 with range on, then external load wins (R7)
        step(0, 0, 0, 1, 1, 4'd13, "R4");
        step(1, 1, 0, 1, 1, 4'd6, "R7");
        // reach 13, clear while stopped beats reload (R7)
        step(0, 0, 0, 1, 1, 4'd13, "R4");
        step(0, 0, 1, 0, 1, 4'd0, "R7");
        // range off: 13 passes to 14 (R11)
        step(0, 0, 0, 1, 0, 4'd12, "R4");
        for (int i = 0; i < 4; i++) step(1, 1, 1, 1, 0, 4'd0, "R11");

        @(negedge clk); @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule